// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the master side of an external bus on which address and data share one set of wires. When idle it takes a request that carries an address, write data, a direction flag and a memory-or-I/O flag. It then runs one bus cycle through four timing phases, T1, T2, T3 and T4, and each phase lasts two system clocks. In T1 the address goes out on the shared bus while the address strobe pulses, so an external latch can hold the address. From T2 onward the bus carries write data, or it is released so the addressed device can drive read data.

A slow device stretches the cycle by pulling the active-low ready input low. The controller samples that input on the last clock of T2 and inserts whole wait phases between T3 and T4 until the input returns high. Read data is captured on the edge that enters T4. A one-clock completion pulse follows T4, and the captured read data is valid during that pulse.

Top module: `mux_bus_ctrl`

## Requirements
- R1: An accepted cycle runs T1, T2, T3, any wait phases, then T4. Each phase lasts two clocks, so a cycle without waits takes 8 clocks from the accepting edge to the return to idle.
- R2: During T1, `bus_out` carries the request address with `bus_oe` high and `cs_n` low. `ale` is high only on the first clock of T1.
- R3: For a read, `bus_oe` is low from T2 through T4. `rd_n` is low during T2, T3 and all wait phases, and it is high in T4.
- R4: For a write, `bus_out` carries the write data with `bus_oe` high from T2 through T4. `wr_n` is low during T2, T3 and all wait phases, and it is high in T4. `rd_n` and `wr_n` are never low together.
- R5: `cs_n` is low from T1 through T4. From T2 through T4, `iorq_n` is low when `req_io`=1 and `mreq_n` is low when `req_io`=0. The two are never low together.
- R6: `ready_n` is sampled on the last clock of T2. If it is low there, at least one wait phase follows T3. If it is high there, T4 follows T3 directly.
- R7: Each wait phase lasts two clocks. On the last clock of a wait phase, a low `ready_n` adds another wait phase and a high `ready_n` leads to T4.
- R8: For a read, `rd_data` takes the value of `bus_in` at the edge that enters T4. Later changes of `bus_in` and write cycles leave `rd_data` unchanged.
- R9: `done` is high for exactly one clock, on the first clock after T4.
- R10: `req` is ignored while a cycle is in progress. The latched address and data are not affected by port changes during the cycle.
- R11: After reset the block is idle: `ale`=0, `bus_oe`=0, `bus_out`=0, all active-low strobes high, `done`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a bus cycle (accepted only while idle) |
| req_addr | input | BUS_W | Address of the cycle |
| req_wdata | input | BUS_W | Data for a write cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| ready_n | input | 1 | Active-low wait request from the device |
| bus_in | input | BUS_W | Shared bus value as seen at the pins |
| bus_out | output | BUS_W | Value driven onto the shared bus |
| bus_oe | output | 1 | Enables the shared bus driver |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mreq_n | output | 1 | Active-low memory-access qualifier |
| iorq_n | output | 1 | Active-low I/O-access qualifier |
| cs_n | output | 1 | Active-low chip select |
| rd_data | output | BUS_W | Captured read data |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bound assertions check the cycle-independent pin rules on every clock. These rules are: the strobes are mutually exclusive, the bus driver is off while the read strobe is low and on while the write strobe is low, the address strobe lasts one clock and comes only with chip select and the address driven, and the completion pulse lasts one clock. The phase durations, the number of wait phases produced by a given ready pattern, the exact sampling edge for read data, and the ignoring of requests during a cycle depend on how stimulus lines up with the clock. Only the bench scenarios show these, by comparing every pin on every clock with a model computed from the request and the ready pattern.

// File: rtl/mbc_pkg.sv
// Package: shared phase encoding for the multiplexed bus controller.
// Assumes: one phase value per T state, plus idle and a wait phase.
package mbc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;
endpackage

// File: rtl/mbc_sequencer.sv
// Module: phase sequencer. It steps IDLE -> T1 -> T2 -> T3 -> [TW...] -> T4 -> IDLE,
// and each phase lasts two clocks (half = 0, then 1).
// Assumes: ready_n is synchronous to clk. It is sampled on the last clock of T2
// and on the last clock of every wait phase.
module mbc_sequencer
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   ready_n,
    output phase_e phase,
    output logic   half,
    output logic   accept,
    output logic   enter_t4,
    output logic   cycle_end
);
    logic wait_q;

    // Strobes for the capture stage, decoded from the current phase.
    always_comb begin
        accept    = (phase == PH_IDLE) && req;
        enter_t4  = half && (((phase == PH_T3) && !wait_q) ||
                             ((phase == PH_TW) && ready_n));
        cycle_end = half && (phase == PH_T4);
    end

    // Phase register, half counter and the wait request latched at the end of T2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            half   <= 1'b0;
            wait_q <= 1'b0;
        end else if (phase == PH_IDLE) begin
            half <= 1'b0;
            if (req) phase <= PH_T1;
        end else begin
            half <= ~half;
            if (half) begin
                case (phase)
                    PH_T1: phase <= PH_T2;
                    PH_T2: begin
                        phase  <= PH_T3;
                        wait_q <= !ready_n;
                    end
                    PH_T3: phase <= wait_q ? PH_TW : PH_T4;
                    PH_TW: phase <= ready_n ? PH_T4 : PH_TW;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbc_capture.sv
// Module: request latch and read capture. It holds the request fields for the whole
// cycle, samples bus_in when T4 is entered on a read, and makes the done pulse.
// Assumes: accept is high only while the sequencer is idle.
module mbc_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             enter_t4,
    input  logic             cycle_end,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic             req_write,
    input  logic             req_io,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] lat_addr,
    output logic [BUS_W-1:0] lat_wdata,
    output logic             lat_write,
    output logic             lat_io,
    output logic [BUS_W-1:0] rd_data,
    output logic             done
);
    // Latch the request fields when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_io    <= req_io;
        end
    end

    // Sample read data on entry to T4 and raise done for one clock after T4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= cycle_end;
            if (enter_t4 && !lat_write) rd_data <= bus_in;
        end
    end
endmodule

// File: rtl/mbc_pin_decode.sv
// Module: pin decoder. It turns the phase, the half clock and the latched request
// into the bus pins. It is purely combinational, and every output depends only on registers.
// Assumes: lat_* fields are stable while the phase is not idle.
module mbc_pin_decode
    import mbc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  phase_e           phase,
    input  logic             half,
    input  logic             lat_write,
    input  logic             lat_io,
    input  logic [BUS_W-1:0] lat_addr,
    input  logic [BUS_W-1:0] lat_wdata,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             mreq_n,
    output logic             iorq_n,
    output logic             cs_n
);
    logic in_t1, data_ph, strobe_ph;

    // Phase groups, then pin levels for each group.
    always_comb begin
        in_t1     = (phase == PH_T1);
        data_ph   = (phase == PH_T2) || (phase == PH_T3) ||
                    (phase == PH_TW) || (phase == PH_T4);
        strobe_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
        ale       = in_t1 && !half;
        cs_n      = !(in_t1 || data_ph);
        rd_n      = !(strobe_ph && !lat_write);
        wr_n      = !(strobe_ph && lat_write);
        mreq_n    = !(data_ph && !lat_io);
        iorq_n    = !(data_ph && lat_io);
        bus_oe    = in_t1 || (data_ph && lat_write);
        if (in_t1)                      bus_out = lat_addr;
        else if (data_ph && lat_write)  bus_out = lat_wdata;
        else                            bus_out = '0;
    end
endmodule

// File: rtl/mux_bus_ctrl.sv
// Module: top of the multiplexed address/data bus master. It joins the sequencer,
// the request/capture stage and the pin decoder.
// Assumes: the pad logic outside joins bus_out/bus_oe/bus_in into the shared bus.
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic             req_write,
    input  logic             req_io,
    input  logic             ready_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             mreq_n,
    output logic             iorq_n,
    output logic             cs_n,
    output logic [BUS_W-1:0] rd_data,
    output logic             done
);
    phase_e           phase;
    logic             half, accept, enter_t4, cycle_end;
    logic [BUS_W-1:0] lat_addr, lat_wdata;
    logic             lat_write, lat_io;

    mbc_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .ready_n(ready_n),
        .phase(phase), .half(half), .accept(accept),
        .enter_t4(enter_t4), .cycle_end(cycle_end)
    );

    mbc_capture #(.BUS_W(BUS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .accept(accept), .enter_t4(enter_t4),
        .cycle_end(cycle_end), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_io(req_io), .bus_in(bus_in),
        .lat_addr(lat_addr), .lat_wdata(lat_wdata), .lat_write(lat_write),
        .lat_io(lat_io), .rd_data(rd_data), .done(done)
    );

    mbc_pin_decode #(.BUS_W(BUS_W)) u_dec (
        .phase(phase), .half(half), .lat_write(lat_write), .lat_io(lat_io),
        .lat_addr(lat_addr), .lat_wdata(lat_wdata), .bus_out(bus_out),
        .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .cs_n(cs_n)
    );
endmodule

// File: rtl/mbc_checker.sv
// Module: checker for the pin rules that hold on every cycle. It is bound to mux_bus_ctrl.
// Assumes: it observes top-level ports only.
module mbc_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic mreq_n,
    input logic iorq_n,
    input logic cs_n,
    input logic done
);
    assert_ale_with_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (!cs_n && bus_oe));
    assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    assert_read_bus_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);
    assert_write_bus_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_oe);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_space_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mreq_n && !iorq_n));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mux_bus_ctrl mbc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .cs_n(cs_n), .done(done)
);

// File: tb/tb_mux_bus_ctrl.sv
`timescale 1ns/1ps
module tb_mux_bus_ctrl;
    localparam int BW = 16;
    localparam int VW = BW + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [BW-1:0] req_addr = '0, req_wdata = '0, bus_in = '0;
    logic          req_write = 1'b0, req_io = 1'b0, ready_n = 1'b1;
    logic [BW-1:0] bus_out, rd_data;
    logic          bus_oe, ale, rd_n, wr_n, mreq_n, iorq_n, cs_n, done;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [BW-1:0] last_rd = '0;

    always #2.5 clk = ~clk;

    mux_bus_ctrl #(.BUS_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .ready_n(ready_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .cs_n(cs_n), .rd_data(rd_data), .done(done)
    );

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Number of wait phases when ready_n is low at edges 1..u after the accepting edge.
    function automatic int waits_for(input int u);
        int j;
        if (u < 4) return 0;
        j = 1;
        while (6 + 2*j <= u) j++;
        return j;
    endfunction

    // Pin vector {ale,cs_n,rd_n,wr_n,mreq_n,iorq_n,oe,bus} m clocks after the accept edge.
    function automatic logic [VW-1:0] exp_pins(input int m, input int k, input logic wr,
                                               input logic io, input logic [BW-1:0] a,
                                               input logic [BW-1:0] d);
        logic [VW-1:0] v;
        v = {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, {BW{1'b0}}};
        if (m < 2) v = {(m == 0), 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, a};
        else if (m < 8 + 2*k) begin
            v = {1'b0, 1'b0, !(m < 6 + 2*k) | wr, !(m < 6 + 2*k) | !wr,
                 io, !io, wr, wr ? d : {BW{1'b0}}};
        end
        return v;
    endfunction

    function automatic string tag_for(input int m, input int k, input logic wr);
        if (m < 2) return "R2";
        if (m < 4) return wr ? "R4" : "R3";
        if (m < 6) return "R6";
        if (m < 6 + 2*k) return "R7";
        if (m < 8 + 2*k) return "R1";
        return "R10";
    endfunction

    function automatic logic [VW-1:0] pins();
        return {ale, cs_n, rd_n, wr_n, mreq_n, iorq_n, bus_oe, bus_out};
    endfunction

    // One bus cycle; ready_n is low at edges 1..u; inject = stray request mid-cycle (R10).
    task automatic run_cycle(input logic [BW-1:0] a, input logic [BW-1:0] d, input logic wr,
                             input logic io, input int u, input logic inject);
        int k;
        logic [BW-1:0] rv;
        k  = waits_for(u);
        rv = BW'($urandom);
        @(negedge clk);
        req = 1'b1; req_addr = a; req_wdata = d; req_write = wr; req_io = io;
        bus_in = rv; ready_n = 1'b0;
        @(posedge clk);
        for (int m = 0; m <= 9 + 2*k; m++) begin
            @(negedge clk);
            req = inject && (m == 3);
            if (m == 3) begin req_addr = ~a; req_wdata = ~d; req_write = !wr; req_io = !io; end
            ready_n = !(m + 1 <= u);
            if (m == 6 + 2*k) bus_in = ~rv;
            check(tag_for(m, k, wr), pins(), exp_pins(m, k, wr, io, a, d));
            if (m == 2) check("R5", VW'({mreq_n, iorq_n}), VW'({io, !io}));
            if (m == 8 + 2*k) begin
                check("R9", VW'(done), VW'(1));
                if (!wr) last_rd = rv;
                check("R8", VW'(rd_data), VW'(last_rd));
            end else begin
                check("R9", VW'(done), VW'(0));
            end
        end
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R11", pins(), {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, {BW{1'b0}}});
        check("R11", VW'({done, rd_data}), '0);
        // Directed corners: no wait, ready low only before T2 end, exact boundary, long stretch.
        run_cycle(16'h1234, 16'hABCD, 1'b0, 1'b0, 0, 1'b0);
        run_cycle(16'h2345, 16'h5A5A, 1'b1, 1'b1, 3, 1'b0);
        run_cycle(16'h3456, 16'h0F0F, 1'b0, 1'b1, 4, 1'b1);
        run_cycle(16'h4567, 16'hF00D, 1'b1, 1'b0, 4, 1'b1);
        run_cycle(16'h5678, 16'h1111, 1'b0, 1'b0, 11, 1'b0);
        run_cycle(16'h6789, 16'h2222, 1'b1, 1'b0, 12, 1'b0);
        // Random mix.
        for (int i = 0; i < 40; i++) begin
            run_cycle(BW'($urandom), BW'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom_range(0, 14)), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule